// File: doc/BRIEF.md
# Transmit Echo Verification Checker

This block confirms, without processor involvement, that every character a serial transmitter sends comes back intact from a remote station that loops the line back to it. Each byte the transmitter pushes is held in a short pending queue. The block deserializes the returned serial line one sample per bit. It samples on the rising or the falling edge of the local transmit bit clock, as software selects, so that an echo arriving about half a bit late is sampled near the middle of each bit. Each returned character is compared against the oldest pending byte.

A wrong byte, a bad parity bit, a missing stop bit, an echo with nothing pending, or a third push while two bytes still wait all set a sticky error flag, and that flag drives an interrupt request. Software reads the flag and the mode through one 8-bit register and clears the flag by writing a 1 to its bit. The transmitter and the baud generator sit outside the block. Both bit clock edges reach the block as one-cycle strobes in the system clock domain.

Top module: `echo_check`

## Requirements
- R1: After reset the register reads 8'h00, `irq` is low and no byte is pending.
- R2: The register reads {4'b0000, err, mode[1:0], 1'b0}: the error flag in bit 3 and the mode in bits 2:1. A write loads bits 2:1 of the write data into the mode.
- R3: Mode 2'b01 samples `rtn_line` only in cycles where `bclk_rise` is high. Mode 2'b10 samples it only in cycles where `bclk_fall` is high.
- R4: Modes 2'b00 and 2'b11 sample nothing, store no pushed byte and raise no error.
- R5: A returned frame is a low start bit seen at a sample while idle, then 8 data bits sent LSB first, then a parity bit only when `par_en` is 1, then a stop bit that must be high. With `par_odd`=0 the data bits and the parity bit together hold an even number of ones. With `par_odd`=1 they hold an odd number.
- R6: A returned frame whose byte equals the oldest pending byte, with correct parity and stop bit, removes that byte and leaves the error flag unchanged.
- R7: A returned byte that differs from the oldest pending byte sets the error flag.
- R8: A wrong parity bit sets the error flag.
- R9: A low stop bit sets the error flag.
- R10: A returned frame that completes while no byte is pending sets the error flag.
- R11: At most 2 bytes are pending. A push while 2 are pending sets the error flag, drops the oldest byte and keeps the new one.
- R12: The error flag is sticky and `irq` follows it. A write with bit 3 = 1 clears the flag, and a write with bit 3 = 0 leaves it alone. If a new error occurs in the same cycle as a clearing write, the flag stays set.
- R13: A write that changes the mode empties the queue and returns the deserializer to idle, but keeps the error flag. A push in that same cycle is dropped. A write that keeps the mode flushes nothing.
- R14: A completed frame releases its pending byte at the clock edge one cycle after the edge that sampled its stop bit. A push at that same edge, with 2 bytes pending, is not an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_push | input | 1 | One-cycle strobe: transmitter sent `tx_byte` |
| tx_byte | input | 8 | Byte being sent |
| rtn_line | input | 1 | Serial line returned by the remote station |
| bclk_rise | input | 1 | One-cycle strobe at each transmit bit clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe at each transmit bit clock falling edge |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request, high while the error flag is set |

## Verification
The release of a pending byte by a finished echo can fall in the same cycle as a new push, and a clearing write can fall in the same cycle as a freshly detected error. The bench provokes both by acting in the cycle that directly follows the stop-bit sample strobe. It first fills the queue and then pushes a third byte at that moment. The flag must stay low, and the two later echoes must both match. In a second run a mismatched echo meets a clearing write at that moment, and the flag must remain high. Each returned character also carries the opposite bit levels on the unselected clock edge, so that sampling on the wrong edge shows up as an error.

// File: rtl/echo_pkg.sv
// Package: shared constants and types of the transmit echo checker.
// Assumes an 8-bit character and a 2-bit mode field.
package echo_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RISE = 2'b01,
        MODE_FALL = 2'b10,
        MODE_RSVD = 2'b11
    } echo_mode_e;

    typedef enum logic [1:0] {
        DS_IDLE = 2'b00,
        DS_DATA = 2'b01,
        DS_PAR  = 2'b10,
        DS_STOP = 2'b11
    } deser_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } rx_char_t;

endpackage

// File: rtl/echo_smp_sel.sv
// Module: echo_smp_sel
// Chooses which transmit bit clock strobe samples the returned line, from
// the mode field. Assumes both strobes are one system clock wide. The
// reserved code behaves exactly like the disabled code.
module echo_smp_sel
    import echo_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       rise_stb,
    input  logic       fall_stb,
    output logic       smp,
    output logic       active
);

    // Decode the mode into a sample strobe and an enable.
    always_comb begin
        smp    = 1'b0;
        active = 1'b0;
        case (echo_mode_e'(mode))
            MODE_RISE: begin
                smp    = rise_stb;
                active = 1'b1;
            end
            MODE_FALL: begin
                smp    = fall_stb;
                active = 1'b1;
            end
            default: begin
                smp    = 1'b0;
                active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/echo_deser.sv
// Module: echo_deser
// Deserializes the returned line at one sample per bit: start bit (low),
// DATA_W data bits LSB first, optional parity bit, stop bit. It raises a
// one-cycle registered done pulse, with the byte and its fault bits, in the
// cycle after the stop bit sample. Assumes par_en and par_odd stay steady
// during a frame. flush returns it to idle.
module echo_deser
    import echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              smp,
    input  logic              line,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_bad,
    output logic              stop_bad,
    output logic              busy
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    deser_state_e      state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              pbit_q;

    // Frame state machine, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state_q  <= DS_IDLE;
            idx_q    <= '0;
            shift_q  <= '0;
            pbit_q   <= 1'b0;
            done     <= 1'b0;
            data     <= '0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (smp) begin
                case (state_q)
                    DS_IDLE: begin
                        if (!line) begin
                            state_q <= DS_DATA;
                            idx_q   <= '0;
                        end
                    end
                    DS_DATA: begin
                        shift_q <= {line, shift_q[DATA_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            state_q <= par_en ? DS_PAR : DS_STOP;
                        end
                    end
                    DS_PAR: begin
                        pbit_q  <= line;
                        state_q <= DS_STOP;
                    end
                    DS_STOP: begin
                        done     <= 1'b1;
                        data     <= shift_q;
                        par_bad  <= par_en && ((^shift_q ^ pbit_q) != par_odd);
                        stop_bad <= !line;
                        state_q  <= DS_IDLE;
                    end
                    default: state_q <= DS_IDLE;
                endcase
            end
        end
    end

    // Busy whenever a frame is in progress.
    assign busy = (state_q != DS_IDLE);

endmodule

// File: rtl/echo_pend_q.sv
// Module: echo_pend_q
// Circular queue of sent bytes waiting for their echo. A pop and a push may
// fall in the same cycle; the pop is counted first. A push into a queue that
// stays full drops the oldest entry and reports ovf. flush empties it.
module echo_pend_q #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic              valid,
    output logic [DATA_W-1:0] head,
    output logic              ovf,
    output logic [CNT_W-1:0]  cnt
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop_ok;
    logic [CNT_W-1:0]  cnt_after;
    logic              full_after;

    // Next pointer with wrap for any depth.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Occupancy after the pop, and overflow decision.
    always_comb begin
        pop_ok     = pop && (cnt_q != '0);
        cnt_after  = cnt_q - CNT_W'(pop_ok);
        full_after = (cnt_after == FULL_CNT);
        ovf        = push && full_after && !flush;
    end

    // One storage slot per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !flush && (wr_q == PTR_W'(g))) begin
                mem[g] <= din;
            end
        end
    end

    // Pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= nxt(wr_q);
            end
            if (pop_ok || ovf) begin
                rd_q <= nxt(rd_q);
            end
            if (push) begin
                cnt_q <= full_after ? cnt_after : cnt_after + 1'b1;
            end else begin
                cnt_q <= cnt_after;
            end
        end
    end

    assign valid = (cnt_q != '0);
    assign head  = mem[rd_q];
    assign cnt   = cnt_q;

endmodule

// File: rtl/echo_stat_reg.sv
// Module: echo_stat_reg
// Holds the mode field and the sticky error flag behind one 8-bit register.
// A write that changes the mode produces a same-cycle flush. A new error in
// the same cycle as a clearing write wins.
module echo_stat_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       err_set,
    output logic [1:0] mode,
    output logic       err,
    output logic       flush,
    output logic [7:0] rdata
);

    localparam int ERR_BIT  = 3;
    localparam int MODE_LSB = 1;

    logic [1:0] mode_q;
    logic       err_q;
    logic       clr;
    logic       unused_wbits;

    assign unused_wbits = ^{wdata[7:4], wdata[0]};
    assign clr   = wr && wdata[ERR_BIT];
    assign flush = wr && (wdata[MODE_LSB+1:MODE_LSB] != mode_q);

    // Mode field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
        end else if (wr) begin
            mode_q <= wdata[MODE_LSB+1:MODE_LSB];
        end
    end

    // Sticky error flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= (err_q && !clr) || err_set;
        end
    end

    assign mode  = mode_q;
    assign err   = err_q;
    assign rdata = {4'b0000, err_q, mode_q, 1'b0};

endmodule

// File: rtl/echo_check.sv
// Module: echo_check (top)
// Stores each transmitted byte and checks it against the echo returned by
// a remote loopback, sampled on the edge of the transmit bit clock that the
// mode selects. Faults set a sticky flag that drives irq. Assumes the bit
// clock strobes are synchronous one-cycle pulses, at one per bit.
module echo_check
    import echo_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int DATA_W = CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rtn_line,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]        mode;
    logic              err;
    logic              flush;
    logic              smp;
    logic              active;
    logic              des_done;
    logic [DATA_W-1:0] des_data;
    logic              des_pbad;
    logic              des_sbad;
    logic              des_busy;
    logic              push_eff;
    logic              q_valid;
    logic [DATA_W-1:0] q_head;
    logic              q_ovf;
    logic [CNT_W-1:0]  pend_cnt;
    logic              cmp_fault;
    logic              err_set;

    echo_stat_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .err_set (err_set),
        .mode    (mode),
        .err     (err),
        .flush   (flush),
        .rdata   (reg_rdata)
    );

    echo_smp_sel u_sel (
        .mode     (mode),
        .rise_stb (bclk_rise),
        .fall_stb (bclk_fall),
        .smp      (smp),
        .active   (active)
    );

    echo_deser #(.DATA_W(DATA_W)) u_des (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .smp      (smp),
        .line     (rtn_line),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .done     (des_done),
        .data     (des_data),
        .par_bad  (des_pbad),
        .stop_bad (des_sbad),
        .busy     (des_busy)
    );

    // Only store bytes while checking is on and no flush is happening.
    assign push_eff = tx_push && active && !flush;

    echo_pend_q #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push_eff),
        .din   (tx_byte),
        .pop   (des_done && !flush),
        .valid (q_valid),
        .head  (q_head),
        .ovf   (q_ovf),
        .cnt   (pend_cnt)
    );

    // Judge a finished echo against the oldest pending byte.
    always_comb begin
        cmp_fault = 1'b0;
        if (des_done && !flush) begin
            cmp_fault = !q_valid || (des_data != q_head) || des_pbad || des_sbad;
        end
        err_set = cmp_fault || q_ovf;
    end

    assign irq = err;

endmodule

// File: rtl/echo_check_sva.sv
// Module: echo_check_sva
// Checker bound to echo_check. Watches the register port, the flag, the
// queue occupancy and the deserializer state.
module echo_check_sva #(
    parameter int DEPTH = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       reg_rdata,
    input logic             irq,
    input logic [CNT_W-1:0] pend_cnt,
    input logic             err_set,
    input logic             des_busy
);

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_wdata[3])) |=> irq);

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[3] && !err_set) |=> !irq);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CNT_W'(DEPTH));

    assert_disabled_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2:1] == 2'b00 || reg_rdata[2:1] == 2'b11) |-> pend_cnt == '0);

    assert_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2:1] != reg_rdata[2:1]) |=> (pend_cnt == '0 && !des_busy));

    assert_mode_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[2:1] == $past(reg_wdata[2:1]));

    assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(err_set));

endmodule

bind echo_check echo_check_sva #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .pend_cnt  (pend_cnt),
    .err_set   (err_set),
    .des_busy  (des_busy)
);

// File: tb/sim_echo_check.sv
// Bench for echo_check: sweeps bytes and parity settings, then the corner
// cases (overflow, orphan echo, flush, same-cycle events).
module sim_echo_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_push = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rtn_line = 1'b1;
    logic       bclk_rise = 1'b0;
    logic       bclk_fall = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    bit  use_fall = 1'b0;
    logic [1:0] cur_mode = 2'b00;

    always #5 clk = ~clk;

    echo_check u0 (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_byte(tx_byte),
        .rtn_line(rtn_line), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .par_en(par_en), .par_odd(par_odd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        @(negedge clk);
        chk(irq === exp && reg_rdata[3] === exp, req, int'(irq), int'(exp));
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (!(v[3] && v[2:1] == cur_mode)) cur_mode = v[2:1];
    endtask

    task automatic clear_err();
        wr_reg({4'b0000, 1'b1, cur_mode, 1'b0});
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        tx_push = 1'b1; tx_byte = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    // One strobe; act 1 pushes ab, act 2 writes a clear, in the next cycle.
    task automatic pulse(input bit rise, input int act, input logic [7:0] ab);
        @(negedge clk);
        if (rise) bclk_rise = 1'b1; else bclk_fall = 1'b1;
        @(negedge clk);
        bclk_rise = 1'b0; bclk_fall = 1'b0;
        if (act == 1) begin tx_push = 1'b1; tx_byte = ab; end
        if (act == 2) begin reg_wr = 1'b1; reg_wdata = {4'b0000, 1'b1, cur_mode, 1'b0}; end
        @(negedge clk);
        tx_push = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
    endtask

    // One bit time: wanted level on the selected edge, inverse on the other.
    task automatic slot(input logic v, input int act, input logic [7:0] ab);
        rtn_line = use_fall ? ~v : v;
        pulse(1'b1, use_fall ? 0 : act, ab);
        rtn_line = use_fall ? v : ~v;
        pulse(1'b0, use_fall ? act : 0, ab);
    endtask

    task automatic send_char(input logic [7:0] d, input bit bpar, input bit bstop,
                             input int act, input logic [7:0] ab);
        slot(1'b0, 0, 8'h00);
        for (int i = 0; i < 8; i++) slot(d[i], 0, 8'h00);
        if (par_en) slot((^d) ^ par_odd ^ bpar, 0, 8'h00);
        slot(~bstop, act, ab);
        slot(1'b1, 0, 8'h00);
        slot(1'b1, 0, 8'h00);
        rtn_line = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata === 8'h00, "R1 rdata", int'(reg_rdata), 'h00);
        chk(irq === 1'b0, "R1 irq", int'(irq), 0);

        // R4 mode 00: push ignored, echo raises nothing
        push(8'h5A);
        send_char(8'h33, 0, 0, 0, 8'h00);
        chk_irq(1'b0, "R4 off");
        // R4 mode 11 reads back but stays disabled
        wr_reg(8'h06);
        chk(reg_rdata === 8'h06, "R2 rdata mode11", int'(reg_rdata), 'h06);
        push(8'hC3);
        send_char(8'h11, 0, 0, 0, 8'h00);
        chk_irq(1'b0, "R4 rsvd");
        // switch to rising: the earlier push was never stored -> orphan, R10
        wr_reg(8'h02);
        chk(reg_rdata === 8'h02, "R2 rdata mode01", int'(reg_rdata), 'h02);
        send_char(8'hC3, 0, 0, 0, 8'h00);
        chk_irq(1'b1, "R4 R10 orphan");
        // R12 write with bit3 = 0 keeps the flag
        wr_reg(8'h02);
        chk_irq(1'b1, "R12 keep");
        clear_err();
        chk_irq(1'b0, "R12 clear");

        // Sweep all bytes on the rising edge, R3 R5 R6 R7
        for (int d = 0; d < 256; d++) begin
            push(8'(d));
            if (d % 16 == 5) begin
                send_char(8'(d) ^ 8'h10, 0, 0, 0, 8'h00);
                chk_irq(1'b1, "R7 mismatch");
                clear_err();
            end else begin
                send_char(8'(d), 0, 0, 0, 8'h00);
                chk_irq(1'b0, "R6 R3 match rise");
            end
        end

        // R8 parity sweep, both senses
        par_en = 1'b1;
        for (int po = 0; po < 2; po++) begin
            par_odd = po[0];
            for (int k = 0; k < 64; k++) begin
                push(8'(k * 4 + po));
                send_char(8'(k * 4 + po), 0, 0, 0, 8'h00);
                chk_irq(1'b0, "R5 parity good");
                push(8'(k * 4 + po));
                send_char(8'(k * 4 + po), 1, 0, 0, 8'h00);
                chk_irq(1'b1, "R8 parity bad");
                clear_err();
            end
        end
        par_en = 1'b0; par_odd = 1'b0;

        // R9 framing
        push(8'hA5);
        send_char(8'hA5, 0, 1, 0, 8'h00);
        chk_irq(1'b1, "R9 stop low");
        clear_err();

        // R11 overflow drops oldest
        push(8'h01); push(8'h02);
        chk_irq(1'b0, "R11 two pending");
        push(8'h03);
        chk_irq(1'b1, "R11 third push");
        clear_err();
        send_char(8'h02, 0, 0, 0, 8'h00);
        send_char(8'h03, 0, 0, 0, 8'h00);
        chk_irq(1'b0, "R11 oldest dropped");
        send_char(8'h03, 0, 0, 0, 8'h00);
        chk_irq(1'b1, "R10 empty");
        clear_err();

        // R14 push in the release cycle with a full queue
        push(8'h41); push(8'h42);
        send_char(8'h41, 0, 0, 1, 8'h43);
        chk_irq(1'b0, "R14 same-cycle push");
        send_char(8'h42, 0, 0, 0, 8'h00);
        send_char(8'h43, 0, 0, 0, 8'h00);
        chk_irq(1'b0, "R14 later echoes");

        // R12 new error in the clearing cycle wins
        push(8'h77);
        send_char(8'h78, 0, 0, 2, 8'h00);
        chk_irq(1'b1, "R12 set wins");
        clear_err();

        // R3 falling edge, wrong-edge data inverted
        wr_reg(8'h04);
        use_fall = 1'b1;
        for (int d = 0; d < 256; d += 17) begin
            push(8'(d));
            send_char(8'(d), 0, 0, 0, 8'h00);
            chk_irq(1'b0, "R3 match fall");
        end

        // R13 same-mode write keeps the queue
        push(8'h9C);
        wr_reg(8'h04);
        send_char(8'h9C, 0, 0, 0, 8'h00);
        chk_irq(1'b0, "R13 same mode");
        // R13 mode change flushes but keeps the flag
        push(8'h66);
        wr_reg(8'h02);
        use_fall = 1'b0;
        push(8'h10);
        send_char(8'h00, 0, 0, 0, 8'h00);
        chk_irq(1'b1, "R13 flag set by mismatch");
        wr_reg(8'h04);
        use_fall = 1'b1;
        chk_irq(1'b1, "R13 flag kept");
        clear_err();
        send_char(8'h66, 0, 0, 0, 8'h00);
        chk_irq(1'b1, "R13 queue flushed");
        clear_err();
        chk(reg_rdata === 8'h04, "R2 final rdata", int'(reg_rdata), 'h04);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule